// File: doc/BRIEF.md
# Paired-Channel PWM with Shared Clock Path

This block generates two pulse-width-modulated outputs that share one clock source path. The path picks one of two timing sources, gates it, and divides it by a power of two. Each channel then divides the result again with its own 8-bit prescaler. It runs a 16-bit counter whose period and duty come from one 32-bit word. The active output level of each channel can be chosen.

The whole design runs on the system clock `clk`. The two timing sources arrive as one-cycle tick strobes, not as separate clocks. The "source clock" that a channel can send straight to its pin is a square wave held inside the block. It toggles on every tick that leaves the shared divider.

Software or a neighbouring block sets the unit up through a word-addressed write port. Period and duty changes are double-buffered, so every PWM cycle that has started finishes with the settings it began with.

Top module: `pwm_pair`

## Requirements
- R1: After a synchronous active-low reset, every register reads as zero and both channels are disabled. Both outputs drive 1, which is the inactive level for active level 0.
- R2: Writes go to word address 0 (shared clock control), 1 (enable), 2 and 3 (channel 0 control and period/duty), and 4 and 5 (channel 1 control and period/duty). In the clock control word, bit 7 selects source B over source A and bit 4 ungates the chosen source.
- R3: Bits [3:0] of the clock control word hold the pre-divider code i. For i from 0 to 8, the shared divider emits one tick for every 2^i gated source ticks.
- R4: Bits [7:0] of a channel control word hold the prescaler value K. The channel counter advances once for every K+1 shared ticks.
- R5: In the period/duty word, bits [31:16] hold the period minus one (P) and bits [15:0] hold the duty D. The counter runs 0..P and wraps. The output is active while the count is below D, so D = 0 keeps it inactive and D > P keeps it active.
- R6: Bit 8 of a channel control word is the active output level. The inactive level is its complement.
- R7: A period/duty word written while a channel runs takes effect only when the counter wraps. The cycle in progress completes unchanged.
- R8: Clock control bit 5 (channel 0) and bit 6 (channel 1) select bypass. A bypassed, enabled channel outputs the shared source clock, a square wave that toggles on every shared tick, and its duty and active level have no effect.
- R9: Enable word bit c turns on channel c. A disabled channel drives its inactive level, in bypass as well, and keeps its counters at zero. When it is enabled again, its active phase starts on the next clock.
- R10: While the gate bit is 0, no ticks reach the divider or the channels, and every output holds its current level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_a_i | input | 1 | Source A tick strobe, one cycle wide |
| tick_b_i | input | 1 | Source B tick strobe, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register word address |
| wr_data_i | input | 32 | Register write data |
| pwm_o | output | 2 | Channel outputs, bit c for channel c |

## Verification
The bench measures the length of every high and low run on an output and compares it with the run length the requirements predict. A wrong shared divider ratio, a wrong prescaler ratio or an off-by-one period therefore shows up as a run that is too long or too short. A period/duty word is written in the middle of an active phase. A design that applies it at once instead of at the wrap would stretch or cut the low run that follows. The bench also covers duty 0 and duty above the period, a gated-off source, which must freeze the output, and bypass with duty 0 and active level 0, which must still toggle. A channel that is disabled and then enabled again must go active on the very next clock, so a counter that was held rather than cleared would show up as a late first pulse.

// File: rtl/pwm_pair_pkg.sv
`timescale 1ns/1ps
// Shared constants for the paired PWM unit: widths, register addresses and
// bit positions of the clock control word. Assumes exactly two channels.
package pwm_pair_pkg;
    localparam int NCH        = 2;
    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 32;
    localparam int CNT_W      = 16;
    localparam int PSC_W      = 8;
    localparam int DIVC_W     = 4;
    localparam int PREDIV_LOG = 8;
    localparam int CTL_W      = PSC_W + 1;
    localparam int CLKCTL_W   = 8;

    localparam logic [ADDR_W-1:0] A_CLKCTL = 3'd0;
    localparam logic [ADDR_W-1:0] A_ENABLE = 3'd1;
    localparam int                A_CHBASE = 2;

    localparam int B_SRCSEL = 7;
    localparam int B_GATE   = 4;
    localparam int B_BYPASS = 5;
    localparam int B_ACTLVL = PSC_W;
endpackage

// File: rtl/pwm_pair_regs.sv
`timescale 1ns/1ps
// Write-only register file. Decodes word-addressed writes into the shared
// clock control, the enable bits and per-channel control and period/duty.
// Assumes writes are single-cycle strobes; no read path.
module pwm_pair_regs
    import pwm_pair_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    output logic                        src_sel,
    output logic                        gate_en,
    output logic [DIVC_W-1:0]           div_code,
    output logic [NCH-1:0]              bypass,
    output logic [NCH-1:0]              chan_en,
    output logic [NCH-1:0][PSC_W-1:0]   psc_lim,
    output logic [NCH-1:0]              act_lvl,
    output logic [NCH-1:0][CNT_W-1:0]   per_val,
    output logic [NCH-1:0][CNT_W-1:0]   duty_val
);
    logic [CLKCTL_W-1:0] clkctl_q;
    logic [NCH-1:0]      en_q;

    // Shared clock control and enable word storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clkctl_q <= '0;
            en_q     <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CLKCTL) clkctl_q <= wr_data[CLKCTL_W-1:0];
            if (wr_addr == A_ENABLE) en_q     <= wr_data[NCH-1:0];
        end
    end

    assign src_sel  = clkctl_q[B_SRCSEL];
    assign gate_en  = clkctl_q[B_GATE];
    assign div_code = clkctl_q[DIVC_W-1:0];
    assign bypass   = clkctl_q[B_BYPASS +: NCH];
    assign chan_en  = en_q;

    for (genvar c = 0; c < NCH; c++) begin : g_chreg
        localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(A_CHBASE + 2 * c);
        localparam logic [ADDR_W-1:0] PD_ADDR  = ADDR_W'(A_CHBASE + 2 * c + 1);
        logic [CTL_W-1:0]  ctl_q;
        logic [DATA_W-1:0] pd_q;

        // Per-channel control and period/duty storage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctl_q <= '0;
                pd_q  <= '0;
            end else if (wr_en) begin
                if (wr_addr == CTL_ADDR) ctl_q <= wr_data[CTL_W-1:0];
                if (wr_addr == PD_ADDR)  pd_q  <= wr_data;
            end
        end

        assign psc_lim[c]  = ctl_q[PSC_W-1:0];
        assign act_lvl[c]  = ctl_q[B_ACTLVL];
        assign per_val[c]  = pd_q[DATA_W-1 -: CNT_W];
        assign duty_val[c] = pd_q[CNT_W-1:0];
    end
endmodule

// File: rtl/pwm_pair_src.sv
`timescale 1ns/1ps
// Shared source path: selects tick source A or B, gates it, divides by a
// power of two and keeps the square-wave source clock used by bypass.
// Assumes tick inputs are synchronous one-cycle strobes.
module pwm_pair_src #(
    parameter int DIVC_W = 4,
    parameter int MAXLOG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_a,
    input  logic              tick_b,
    input  logic              sel,
    input  logic              gate_en,
    input  logic [DIVC_W-1:0] div_code,
    output logic              src_tick,
    output logic              src_lvl
);
    logic [MAXLOG-1:0] div_cnt;
    logic [MAXLOG-1:0] div_mask;
    logic              raw_tick;

    assign raw_tick = gate_en && (sel ? tick_b : tick_a);

    // Low-bit mask selecting 2^code; codes above MAXLOG saturate
    always_comb begin
        div_mask = '0;
        for (int i = 0; i < MAXLOG; i++) begin
            if (32'(div_code) > i) div_mask[i] = 1'b1;
        end
    end

    assign src_tick = raw_tick && ((div_cnt & div_mask) == div_mask);

    // Pre-divider count and source clock toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            src_lvl <= 1'b0;
        end else begin
            if (raw_tick) div_cnt <= div_cnt + 1'b1;
            if (src_tick) src_lvl <= ~src_lvl;
        end
    end

    // R10
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |=> ($stable(div_cnt) && $stable(src_lvl)));

    // R3
    prediv_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_tick |=> ((div_cnt & $past(div_mask)) == '0));
endmodule

// File: rtl/pwm_pair_chan.sv
`timescale 1ns/1ps
// One PWM channel: prescaler, period counter with shadowed period/duty,
// polarity and bypass selection, registered output.
// Assumes src_tick is a one-cycle strobe from the shared source path.
module pwm_pair_chan #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             bypass,
    input  logic             src_tick,
    input  logic             src_lvl,
    input  logic             act_lvl,
    input  logic [PSC_W-1:0] psc_lim,
    input  logic [CNT_W-1:0] per_in,
    input  logic [CNT_W-1:0] duty_in,
    output logic             pwm_o
);
    logic [PSC_W-1:0] psc_cnt;
    logic             psc_tick;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] duty_q;
    logic             wrap;

    assign psc_tick = src_tick && (psc_cnt >= psc_lim);
    assign wrap     = psc_tick && (cnt >= per_q);

    // Prescaler: one counter step per psc_lim+1 shared ticks
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  psc_cnt <= '0;
        else if (src_tick)  psc_cnt <= psc_tick ? '0 : psc_cnt + 1'b1;
    end

    // Period counter: 0..per_q then wrap
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  cnt <= '0;
        else if (psc_tick)  cnt <= wrap ? '0 : cnt + 1'b1;
    end

    // Shadow period/duty: follow inputs while idle, latch at wrap while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q  <= '0;
            duty_q <= '0;
        end else if (!en || wrap) begin
            per_q  <= per_in;
            duty_q <= duty_in;
        end
    end

    // Output level select: idle, bypass clock or compare result
    always_ff @(posedge clk) begin
        if (!rst_n)       pwm_o <= 1'b1;
        else if (!en)     pwm_o <= ~act_lvl;
        else if (bypass)  pwm_o <= src_lvl;
        else              pwm_o <= (cnt < duty_q) ? act_lvl : ~act_lvl;
    end

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt <= per_q));

    // R7
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wrap) |=> ($stable(per_q) && $stable(duty_q)));

    // R9
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ((pwm_o == !$past(act_lvl)) && (cnt == '0)));

    // R8
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bypass) |=> (pwm_o == $past(src_lvl)));
endmodule

// File: rtl/pwm_pair.sv
`timescale 1ns/1ps
// Top of the paired PWM unit: register file, one shared source path and
// one channel instance per output. Assumes a single clock domain.
module pwm_pair
    import pwm_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_a_i,
    input  logic              tick_b_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [NCH-1:0]    pwm_o
);
    logic                      src_sel;
    logic                      gate_en;
    logic [DIVC_W-1:0]         div_code;
    logic [NCH-1:0]            bypass;
    logic [NCH-1:0]            chan_en;
    logic [NCH-1:0][PSC_W-1:0] psc_lim;
    logic [NCH-1:0]            act_lvl;
    logic [NCH-1:0][CNT_W-1:0] per_val;
    logic [NCH-1:0][CNT_W-1:0] duty_val;
    logic                      src_tick;
    logic                      src_lvl;

    pwm_pair_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en_i),
        .wr_addr  (wr_addr_i),
        .wr_data  (wr_data_i),
        .src_sel  (src_sel),
        .gate_en  (gate_en),
        .div_code (div_code),
        .bypass   (bypass),
        .chan_en  (chan_en),
        .psc_lim  (psc_lim),
        .act_lvl  (act_lvl),
        .per_val  (per_val),
        .duty_val (duty_val)
    );

    pwm_pair_src #(.DIVC_W(DIVC_W), .MAXLOG(PREDIV_LOG)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_a   (tick_a_i),
        .tick_b   (tick_b_i),
        .sel      (src_sel),
        .gate_en  (gate_en),
        .div_code (div_code),
        .src_tick (src_tick),
        .src_lvl  (src_lvl)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pwm_pair_chan #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (chan_en[c]),
            .bypass   (bypass[c]),
            .src_tick (src_tick),
            .src_lvl  (src_lvl),
            .act_lvl  (act_lvl[c]),
            .psc_lim  (psc_lim[c]),
            .per_in   (per_val[c]),
            .duty_in  (duty_val[c]),
            .pwm_o    (pwm_o[c])
        );
    end
endmodule

// File: tb/pwm_pair_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected run lengths, a monitor
// measures high/low runs on the selected output and compares them.
module pwm_pair_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_a = 1'b1;
    logic        tick_b = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  pwm;

    always #2 clk = ~clk;

    pwm_pair u_dut (
        .clk(clk), .rst_n(rst_n), .tick_a_i(tick_a), .tick_b_i(tick_b),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .pwm_o(pwm)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Source B: one tick every third cycle
    int bcnt = 0;
    always @(negedge clk) begin
        bcnt   = (bcnt == 2) ? 0 : bcnt + 1;
        tick_b = (bcnt == 0);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    typedef struct {
        logic  lvl;
        int    len;
        string tag;
    } run_t;
    run_t exp_q[$];

    bit   mon_on = 0;
    int   mon_ch = 0;
    logic prev_lvl = 1'b0;
    logic cur_lvl;
    int   run_len = 0;
    bit   started = 0;
    run_t item;

    // Monitor: measure completed runs, compare with queued expectations
    always @(negedge clk) begin
        cur_lvl = pwm[mon_ch];
        if (!mon_on) begin
            started = 0;
        end else if (cur_lvl === prev_lvl) begin
            run_len++;
        end else begin
            if (started) begin
                if (exp_q.size() > 0) begin
                    item = exp_q.pop_front();
                    check(prev_lvl === item.lvl && run_len == item.len, item.tag,
                          int'(prev_lvl) * 1000 + run_len, int'(item.lvl) * 1000 + item.len);
                end
            end else if (exp_q.size() > 0 && cur_lvl === exp_q[0].lvl) begin
                started = 1;
            end
            run_len = 1;
        end
        prev_lvl = cur_lvl;
    end

    task automatic push(input logic lvl, input int len, input string tag);
        run_t r;
        r.lvl = lvl; r.len = len; r.tag = tag;
        exp_q.push_back(r);
    endtask

    task automatic drain(input int ch, input string tag);
        int t = 0;
        mon_ch = ch;
        mon_on = 1;
        while (exp_q.size() > 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (exp_q.size() > 0) begin
            check(1'b0, {tag, " timeout"}, exp_q.size(), 0);
            exp_q.delete();
        end
        mon_on = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hold_level(input int ch, input logic lvl, input int n, input string tag);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm[ch] !== lvl) bad++;
        end
        check(bad == 0, tag, bad, 0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            check(1'b0, "watchdog expired", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int t;
        int n;
        logic snap;
        idle(3);
        check(pwm === 2'b11, "R1 outputs in reset", int'(pwm), 3);
        rst_n = 1'b1;
        idle(5);
        check(pwm === 2'b11, "R1 outputs after reset", int'(pwm), 3);

        // R5 basic waveform: P=9, D=3, active high, source A, /1 /1
        wr(3'd0, 32'h10);
        wr(3'd2, 32'h100);
        wr(3'd3, {16'd9, 16'd3});
        wr(3'd1, 32'h1);
        idle(30);
        push(1, 3, "R5 active run"); push(0, 7, "R5 inactive run");
        push(1, 3, "R5 active run"); push(0, 7, "R5 inactive run");
        drain(0, "R5");

        // R4 prescaler K=2
        wr(3'd2, 32'h102);
        idle(80);
        push(1, 9, "R4 active run /3"); push(0, 21, "R4 inactive run /3");
        drain(0, "R4");

        // R3 pre-divider code 2 (/4)
        wr(3'd2, 32'h100);
        wr(3'd0, 32'h12);
        idle(100);
        push(1, 12, "R3 active run /4"); push(0, 28, "R3 inactive run /4");
        drain(0, "R3");

        // R2 source B selected (tick every 3 cycles)
        wr(3'd0, 32'h90);
        idle(80);
        push(1, 9, "R2 source B active"); push(0, 21, "R2 source B inactive");
        push(1, 9, "R2 source B active");
        drain(0, "R2");

        // R6 active level 0
        wr(3'd0, 32'h10);
        wr(3'd2, 32'h000);
        idle(30);
        push(0, 3, "R6 active-low run"); push(1, 7, "R6 inactive-high run");
        drain(0, "R6");

        // R5 duty edges
        wr(3'd2, 32'h100);
        wr(3'd3, {16'd9, 16'd0});
        idle(30);
        hold_level(0, 1'b0, 40, "R5 duty zero stays inactive");
        wr(3'd3, {16'd9, 16'd12});
        idle(30);
        hold_level(0, 1'b1, 40, "R5 duty above period stays active");

        // R10 gate off freezes output
        wr(3'd3, {16'd9, 16'd3});
        idle(30);
        wr(3'd0, 32'h00);
        idle(3);
        snap = pwm[0];
        hold_level(0, snap, 60, "R10 gated output frozen");
        wr(3'd0, 32'h10);
        idle(30);

        // R7 shadowed update written mid active phase
        t = 0;
        while (!(prev_lvl === 1'b0 && pwm[0] === 1'b1) && t < 100) begin
            prev_lvl = pwm[0];
            @(negedge clk);
            t++;
        end
        wr(3'd3, {16'd19, 16'd5});
        push(0, 7, "R7 old cycle finishes"); push(1, 5, "R7 new duty");
        push(0, 15, "R7 new period");
        drain(0, "R7");

        // R9 disable and re-enable
        wr(3'd3, {16'd9, 16'd3});
        idle(30);
        wr(3'd1, 32'h0);
        idle(5);
        hold_level(0, 1'b0, 20, "R9 disabled inactive level");
        wr(3'd1, 32'h1);
        t = 0;
        while (pwm[0] !== 1'b1 && t < 50) begin
            @(negedge clk);
            t++;
        end
        check(t == 1, "R9 restart latency", t, 1);
        n = 0;
        while (pwm[0] === 1'b1 && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(n == 3, "R9 first active run", n, 3);

        // R8 bypass ignores duty and level, then disabled bypass idles
        wr(3'd2, 32'h000);
        wr(3'd3, {16'd9, 16'd0});
        wr(3'd0, 32'h31);
        idle(10);
        push(1, 2, "R8 bypass high"); push(0, 2, "R8 bypass low");
        push(1, 2, "R8 bypass high"); push(0, 2, "R8 bypass low");
        drain(0, "R8");
        wr(3'd1, 32'h0);
        idle(3);
        hold_level(0, 1'b1, 20, "R9 disabled bypass idle");

        // R4 channel 1 with its own prescaler, then R8 channel 1 bypass
        wr(3'd0, 32'h10);
        wr(3'd4, 32'h101);
        wr(3'd5, {16'd4, 16'd2});
        wr(3'd1, 32'h3);
        idle(40);
        push(1, 4, "R4 ch1 active"); push(0, 6, "R4 ch1 inactive");
        drain(1, "R4 ch1");
        wr(3'd0, 32'h51);
        idle(10);
        push(1, 2, "R8 ch1 bypass high"); push(0, 2, "R8 ch1 bypass low");
        drain(1, "R8 ch1");

        if (!done) begin
            done = 1;
            summary();
            $finish;
        end
    end
endmodule